// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block holds the stores of an out-of-order core that have been issued but not yet written to memory. A store takes a slot when it is dispatched. Its address and its data are written into that slot later, each one when it becomes known. Memory is written only from the oldest slot, and only after the core says that store has committed. Because of this, memory always sees stores in program order.

A load that has computed its address presents the address together with its age. The age is the allocation position that was current when the load was dispatched. The queue compares the load only against stores older than it and gives one of three answers. It forwards the data of the youngest older store that writes the same address. It stalls the load while that result is not yet certain. Otherwise it sends the load to memory. A flush drops every store from a given position onward, which is how the core recovers from a misspeculation.

Positions are one bit wider than the slot index. The extra bit tells apart two positions that use the same slot but lie on different passes around the ring, so ages can be compared across the wrap.

Top module: `store_fwd_queue`

## Requirements
- R1: `alloc_ready` is high when the queue is not full and no flush is requested. An accepted store gets position `alloc_idx` (the tail position, wrap bit on top), and the tail then moves up by one.
- R2: `mem_we` is high in the same cycle when `drain_req` is high, the oldest store has both address and data, and no flush is requested. `mem_addr` and `mem_data` then carry that store, and the head moves up by one.
- R3: When the queue holds DEPTH stores, `alloc_ready` is low and an `alloc_valid` pulse leaves `alloc_idx` unchanged.
- R4: A load with age A compares only against stores whose position p satisfies (p - head) < (A - head), taken modulo 2*DEPTH. Stores at A or younger are ignored.
- R5: If several older stores with known data match the load address, `ld_data` is the data of the youngest of them and `ld_fwd` is high.
- R6: While `ld_valid` is high, exactly one of `ld_fwd`, `ld_stall` and `ld_mem` is high. While it is low, all three are low.
- R7: The load stalls if any older store still has an unknown address, even when an older store with a known address matches.
- R8: The load stalls if the youngest older matching store has its address but not its data.
- R9: A flush with `flush_ptr` removes every store at that position or younger, and the next `alloc_idx` equals `flush_ptr`.
- R10: In a cycle with a flush request, no store is allocated and none is drained.
- R11: The age comparison and the choice of the youngest match stay correct when the stores wrap around the end of the ring.
- R12: After reset the queue is empty: `alloc_idx` is 0, `alloc_ready` is high and `mem_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request to allocate a store slot |
| alloc_ready | output | 1 | Allocation can be accepted |
| alloc_idx | output | IDX_W+1 | Position given to the next allocated store |
| addr_wr_valid | input | 1 | Write a store address |
| addr_wr_idx | input | IDX_W | Slot whose address is written |
| addr_wr_addr | input | AW | Store address |
| data_wr_valid | input | 1 | Write store data |
| data_wr_idx | input | IDX_W | Slot whose data is written |
| data_wr_data | input | DW | Store data |
| ld_valid | input | 1 | Load query present |
| ld_addr | input | AW | Load address |
| ld_age | input | IDX_W+1 | Allocation position current when the load was dispatched |
| ld_fwd | output | 1 | Forward `ld_data` to the load |
| ld_stall | output | 1 | Retry the load later |
| ld_mem | output | 1 | Load reads memory |
| ld_data | output | DW | Forwarded data |
| drain_req | input | 1 | Oldest store has committed |
| mem_we | output | 1 | Memory write this cycle |
| mem_addr | output | AW | Memory write address |
| mem_data | output | DW | Memory write data |
| flush_valid | input | 1 | Flush request |
| flush_ptr | input | IDX_W+1 | First position removed by the flush |

## Verification
The queue is first filled with a fixed set of stores. In this set some addresses repeat, one store has no address yet, and one has an address but no data. Loads are then issued at every age against this set. These queries separate the choice of the oldest match from the choice of the youngest match. They also separate stores older than the load from stores that are younger, and a hazard from an unknown address from a hazard from missing data.

Further cases follow:
- a drain, which shows that a store leaves the search once it is written to memory;
- a flush issued together with drain and allocation requests, which shows the flush takes priority;
- a fill that wraps around the ring, where the same address sits on both sides of the wrap and the age comparison must pick the newer one.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    LD_TO_MEM   = 2'd0,
    LD_FORWARD  = 2'd1,
    LD_HOLD     = 2'd2
  } ld_result_e;
endpackage

// File: rtl/sq_ptr_ctrl.sv
module sq_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             drain_fire,
  input  logic             flush_valid,
  input  logic [PTR_W-1:0] flush_ptr,
  output logic [PTR_W-1:0] head_q,
  output logic [PTR_W-1:0] tail_q,
  output logic             full,
  output logic             empty
);
  logic [PTR_W-1:0] head_d;
  logic [PTR_W-1:0] tail_d;
  logic [PTR_W-1:0] occ;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    if (drain_fire) head_d = head_q + 1'b1;
    if (flush_valid)     tail_d = flush_ptr;
    else if (alloc_fire) tail_d = tail_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  assign occ   = tail_q - head_q;
  assign full  = (occ == PTR_W'(DEPTH));
  assign empty = (occ == '0);
endmodule

// File: rtl/sq_entry_array.sv
module sq_entry_array #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DEPTH-1:0]         alloc_oh,
  input  logic [DEPTH-1:0]         drain_oh,
  input  logic [DEPTH-1:0]         kill_mask,
  input  logic                     addr_wr_valid,
  input  logic [IDX_W-1:0]         addr_wr_idx,
  input  logic [AW-1:0]            addr_wr_addr,
  input  logic                     data_wr_valid,
  input  logic [IDX_W-1:0]         data_wr_idx,
  input  logic [DW-1:0]            data_wr_data,
  output logic [DEPTH-1:0]         ent_vld,
  output logic [DEPTH-1:0]         ent_aok,
  output logic [DEPTH-1:0]         ent_dok,
  output logic [DEPTH-1:0][AW-1:0] ent_addr,
  output logic [DEPTH-1:0][DW-1:0] ent_data
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic vld_d, aok_d, dok_d;
    logic addr_en, data_en;

    assign addr_en = addr_wr_valid && (addr_wr_idx == IDX_W'(g)) && ent_vld[g];
    assign data_en = data_wr_valid && (data_wr_idx == IDX_W'(g)) && ent_vld[g];

    always_comb begin
      vld_d = ent_vld[g];
      aok_d = ent_aok[g];
      dok_d = ent_dok[g];
      if (addr_en) aok_d = 1'b1;
      if (data_en) dok_d = 1'b1;
      if (drain_oh[g] || kill_mask[g]) begin
        vld_d = 1'b0;
        aok_d = 1'b0;
        dok_d = 1'b0;
      end
      if (alloc_oh[g]) begin
        vld_d = 1'b1;
        aok_d = 1'b0;
        dok_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_vld[g] <= 1'b0;
        ent_aok[g] <= 1'b0;
        ent_dok[g] <= 1'b0;
      end else begin
        ent_vld[g] <= vld_d;
        ent_aok[g] <= aok_d;
        ent_dok[g] <= dok_d;
      end
    end

    always_ff @(posedge clk) begin
      if (addr_en) ent_addr[g] <= addr_wr_addr;
    end

    always_ff @(posedge clk) begin
      if (data_en) ent_data[g] <= data_wr_data;
    end
  end
endmodule

// File: rtl/sq_fwd_search.sv
module sq_fwd_search
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic [IDX_W-1:0]         head_idx,
  input  logic [PTR_W-1:0]         ld_dist,
  input  logic [AW-1:0]            ld_addr,
  input  logic [DEPTH-1:0]         ent_vld,
  input  logic [DEPTH-1:0]         ent_aok,
  input  logic [DEPTH-1:0]         ent_dok,
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [DEPTH-1:0][DW-1:0] ent_data,
  output ld_result_e               result,
  output logic [DW-1:0]            fwd_data
);
  logic             unknown_seen;
  logic             hit_seen;
  logic [IDX_W-1:0] hit_slot;
  logic [IDX_W-1:0] slot;

  // Walk from oldest to youngest; the last hit kept is the youngest one.
  always_comb begin
    unknown_seen = 1'b0;
    hit_seen     = 1'b0;
    hit_slot     = '0;
    slot         = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head_idx + IDX_W'(k);
      if ((PTR_W'(k) < ld_dist) && ent_vld[slot]) begin
        if (!ent_aok[slot]) begin
          unknown_seen = 1'b1;
        end else if (ent_addr[slot] == ld_addr) begin
          hit_seen = 1'b1;
          hit_slot = slot;
        end
      end
    end
  end

  always_comb begin
    fwd_data = ent_data[hit_slot];
    if (unknown_seen)                       result = LD_HOLD;
    else if (hit_seen && !ent_dok[hit_slot]) result = LD_HOLD;
    else if (hit_seen)                      result = LD_FORWARD;
    else                                    result = LD_TO_MEM;
  end
endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  output logic             alloc_ready,
  output logic [PTR_W-1:0] alloc_idx,
  input  logic             addr_wr_valid,
  input  logic [IDX_W-1:0] addr_wr_idx,
  input  logic [AW-1:0]    addr_wr_addr,
  input  logic             data_wr_valid,
  input  logic [IDX_W-1:0] data_wr_idx,
  input  logic [DW-1:0]    data_wr_data,
  input  logic             ld_valid,
  input  logic [AW-1:0]    ld_addr,
  input  logic [PTR_W-1:0] ld_age,
  output logic             ld_fwd,
  output logic             ld_stall,
  output logic             ld_mem,
  output logic [DW-1:0]    ld_data,
  input  logic             drain_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_data,
  input  logic             flush_valid,
  input  logic [PTR_W-1:0] flush_ptr
);
  logic [PTR_W-1:0]         head_q, tail_q;
  logic                     full, empty;
  logic                     alloc_fire, drain_fire, drain_ok;
  logic [IDX_W-1:0]         head_idx, tail_idx;
  logic [DEPTH-1:0]         alloc_oh, drain_oh, kill_mask;
  logic [DEPTH-1:0]         ent_vld, ent_aok, ent_dok;
  logic [DEPTH-1:0][AW-1:0] ent_addr;
  logic [DEPTH-1:0][DW-1:0] ent_data;
  logic [PTR_W-1:0]         ld_dist, flush_dist;
  ld_result_e               result;

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];

  assign alloc_ready = !full && !flush_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign drain_ok    = !empty && ent_vld[head_idx] && ent_aok[head_idx] && ent_dok[head_idx];
  assign drain_fire  = drain_req && drain_ok && !flush_valid;
  assign alloc_idx   = tail_q;

  assign flush_dist = flush_ptr - head_q;
  assign ld_dist    = ld_age - head_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ctl
    logic [IDX_W-1:0] rel;
    assign rel          = IDX_W'(g) - head_idx;
    assign alloc_oh[g]  = alloc_fire && (tail_idx == IDX_W'(g));
    assign drain_oh[g]  = drain_fire && (head_idx == IDX_W'(g));
    assign kill_mask[g] = flush_valid && ({1'b0, rel} >= flush_dist);
  end

  sq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (alloc_fire),
    .drain_fire  (drain_fire),
    .flush_valid (flush_valid),
    .flush_ptr   (flush_ptr),
    .head_q      (head_q),
    .tail_q      (tail_q),
    .full        (full),
    .empty       (empty)
  );

  sq_entry_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_arr (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_oh      (alloc_oh),
    .drain_oh      (drain_oh),
    .kill_mask     (kill_mask),
    .addr_wr_valid (addr_wr_valid),
    .addr_wr_idx   (addr_wr_idx),
    .addr_wr_addr  (addr_wr_addr),
    .data_wr_valid (data_wr_valid),
    .data_wr_idx   (data_wr_idx),
    .data_wr_data  (data_wr_data),
    .ent_vld       (ent_vld),
    .ent_aok       (ent_aok),
    .ent_dok       (ent_dok),
    .ent_addr      (ent_addr),
    .ent_data      (ent_data)
  );

  sq_fwd_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_srch (
    .head_idx (head_idx),
    .ld_dist  (ld_dist),
    .ld_addr  (ld_addr),
    .ent_vld  (ent_vld),
    .ent_aok  (ent_aok),
    .ent_dok  (ent_dok),
    .ent_addr (ent_addr),
    .ent_data (ent_data),
    .result   (result),
    .fwd_data (ld_data)
  );

  assign ld_fwd   = ld_valid && (result == LD_FORWARD);
  assign ld_stall = ld_valid && (result == LD_HOLD);
  assign ld_mem   = ld_valid && (result == LD_TO_MEM);

  assign mem_we   = drain_fire;
  assign mem_addr = ent_addr[head_idx];
  assign mem_data = ent_data[head_idx];
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [PTR_W-1:0] alloc_idx,
  input logic [PTR_W-1:0] head_ptr,
  input logic             mem_we,
  input logic             ld_valid,
  input logic             ld_fwd,
  input logic             ld_stall,
  input logic             ld_mem,
  input logic             flush_valid,
  input logic [PTR_W-1:0] flush_ptr
);
  logic [PTR_W-1:0] occ;
  assign occ = alloc_idx - head_ptr;

  a_r3_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == PTR_W'(DEPTH)) |-> !alloc_ready);

  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ready && !flush_valid) |=> (alloc_idx == $past(alloc_idx)));

  a_r1_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (alloc_idx == $past(alloc_idx) + 1'b1));

  a_r2_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (head_ptr == $past(head_ptr) + 1'b1));

  a_r2_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |=> $stable(head_ptr));

  a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> ($countones({ld_fwd, ld_stall, ld_mem}) == 1));

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> ($countones({ld_fwd, ld_stall, ld_mem}) == 0));

  a_r9_flush_tail: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (alloc_idx == $past(flush_ptr)));

  a_r10_flush_first: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (!mem_we && !alloc_ready));
endmodule

bind store_fwd_queue sq_checker #(.DEPTH(DEPTH)) u_sq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .alloc_idx   (alloc_idx),
  .head_ptr    (head_q),
  .mem_we      (mem_we),
  .ld_valid    (ld_valid),
  .ld_fwd      (ld_fwd),
  .ld_stall    (ld_stall),
  .ld_mem      (ld_mem),
  .flush_valid (flush_valid),
  .flush_ptr   (flush_ptr)
);

// File: tb/tb_store_fwd_queue.sv
`timescale 1ns/1ps
module tb_store_fwd_queue;
  localparam int DEPTH = 8;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int IDX_W = 3;
  localparam int PTR_W = 4;
  localparam logic [1:0] O_MEM = 2'd0, O_FWD = 2'd1, O_STL = 2'd2;

  logic             clk, rst_n;
  logic             alloc_valid, alloc_ready;
  logic [PTR_W-1:0] alloc_idx;
  logic             addr_wr_valid, data_wr_valid;
  logic [IDX_W-1:0] addr_wr_idx, data_wr_idx;
  logic [AW-1:0]    addr_wr_addr, ld_addr, mem_addr;
  logic [DW-1:0]    data_wr_data, ld_data, mem_data;
  logic             ld_valid, ld_fwd, ld_stall, ld_mem;
  logic [PTR_W-1:0] ld_age, flush_ptr;
  logic             drain_req, mem_we, flush_valid;

  int nchk = 0;
  int nerr = 0;

  store_fwd_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {addr, age, outcome, data}; fixed store set built below
  localparam logic [53:0] VEC [9] = '{
    {16'h0010, 4'd1, O_FWD, 32'h000000A0},  // R5 only oldest older
    {16'h0010, 4'd3, O_FWD, 32'h000000C2},  // R5 youngest of two
    {16'h0010, 4'd2, O_FWD, 32'h000000A0},  // R4 younger match ignored
    {16'h0020, 4'd1, O_MEM, 32'h0},         // R4 match is younger
    {16'h0020, 4'd3, O_FWD, 32'h000000B1},  // R5
    {16'h0040, 4'd3, O_MEM, 32'h0},         // R6 no match
    {16'h0010, 4'd0, O_MEM, 32'h0},         // R4 nothing older
    {16'h0040, 4'd4, O_STL, 32'h0},         // R7 unknown address older
    {16'h0010, 4'd5, O_STL, 32'h0}          // R7 despite a known match
  };

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic query(string req, logic [AW-1:0] a, logic [PTR_W-1:0] age,
                       logic [1:0] exp_o, logic [DW-1:0] exp_d);
    logic [1:0] got;
    ld_valid = 1'b1; ld_addr = a; ld_age = age;
    #1;
    got = ld_fwd ? O_FWD : ld_stall ? O_STL : ld_mem ? O_MEM : 2'd3;
    chk(req, 64'(got), 64'(exp_o));
    if (exp_o == O_FWD) chk(req, 64'(ld_data), 64'(exp_d));
    ld_valid = 1'b0;
  endtask

  task automatic alloc_n(int n);
    for (int i = 0; i < n; i++) begin
      alloc_valid = 1'b1; tick();
    end
    alloc_valid = 1'b0;
  endtask

  task automatic set_addr(logic [IDX_W-1:0] i, logic [AW-1:0] a);
    addr_wr_valid = 1'b1; addr_wr_idx = i; addr_wr_addr = a; tick();
    addr_wr_valid = 1'b0;
  endtask

  task automatic set_data(logic [IDX_W-1:0] i, logic [DW-1:0] d);
    data_wr_valid = 1'b1; data_wr_idx = i; data_wr_data = d; tick();
    data_wr_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    alloc_valid = 0; addr_wr_valid = 0; data_wr_valid = 0; ld_valid = 0;
    drain_req = 0; flush_valid = 0;
    addr_wr_idx = '0; addr_wr_addr = '0; data_wr_idx = '0; data_wr_data = '0;
    ld_addr = '0; ld_age = '0; flush_ptr = '0;
    #20; rst_n = 1'b1; tick();

    // R12 reset state
    chk("R12 alloc_idx", 64'(alloc_idx), 64'd0);
    chk("R12 alloc_ready", 64'(alloc_ready), 64'd1);
    chk("R12 mem_we", 64'(mem_we), 64'd0);
    chk("R6 idle outputs", 64'({ld_fwd, ld_stall, ld_mem}), 64'd0);

    // Store set: 0:10/A0 1:20/B1 2:10/C2 3:??? 4:30/no data
    alloc_n(5);
    chk("R1 tail after five", 64'(alloc_idx), 64'd5);
    set_addr(0, 16'h10); set_data(0, 32'hA0);
    set_addr(1, 16'h20); set_data(1, 32'hB1);
    set_addr(2, 16'h10); set_data(2, 32'hC2);
    set_addr(4, 16'h30);

    for (int v = 0; v < 9; v++) begin
      query($sformatf("R4/R5/R7 vec%0d", v), VEC[v][53:38], VEC[v][37:34],
            VEC[v][33:32], VEC[v][31:0]);
    end

    set_addr(3, 16'h30); set_data(3, 32'hD3);
    query("R8 youngest match lacks data", 16'h30, 4'd5, O_STL, 32'h0);
    query("R5 older match with data", 16'h30, 4'd4, O_FWD, 32'hD3);

    // R2 drain of the oldest store
    drain_req = 1'b1; #1;
    chk("R2 mem_we", 64'(mem_we), 64'd1);
    chk("R2 mem_addr", 64'(mem_addr), 64'h10);
    chk("R2 mem_data", 64'(mem_data), 64'hA0);
    tick(); drain_req = 1'b0;
    query("R4 drained store left search", 16'h10, 4'd1, O_MEM, 32'h0);

    // R10 flush wins over drain and allocation
    flush_valid = 1'b1; flush_ptr = 4'd3; drain_req = 1'b1; alloc_valid = 1'b1; #1;
    chk("R10 no drain", 64'(mem_we), 64'd0);
    chk("R10 no alloc", 64'(alloc_ready), 64'd0);
    tick();
    flush_valid = 1'b0; drain_req = 1'b0; alloc_valid = 1'b0;
    chk("R9 tail after flush", 64'(alloc_idx), 64'd3);
    query("R9 survivors kept", 16'h10, 4'd3, O_FWD, 32'hC2);

    // R3 fill to full across the wrap: head=1, positions 3..8
    alloc_n(6);
    chk("R3 tail at full", 64'(alloc_idx), 64'd9);
    chk("R3 not ready", 64'(alloc_ready), 64'd0);
    alloc_n(1);
    chk("R3 refused alloc", 64'(alloc_idx), 64'd9);
    query("R7 unknown after wrap", 16'h10, 4'd9, O_STL, 32'h0);
    for (int s = 3; s < 8; s++) begin
      set_addr(IDX_W'(s), AW'(16'h50 + s));
      set_data(IDX_W'(s), DW'(s));
    end
    set_addr(0, 16'h10); set_data(0, 32'hE8);
    query("R11 youngest across wrap", 16'h10, 4'd9, O_FWD, 32'hE8);
    query("R11 wrapped store is younger", 16'h10, 4'd8, O_FWD, 32'hC2);

    drain_req = 1'b1; #1;
    chk("R2 next in order addr", 64'(mem_addr), 64'h20);
    chk("R2 next in order data", 64'(mem_data), 64'hB1);
    tick(); drain_req = 1'b0;
    chk("R1 ready after drain", 64'(alloc_ready), 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule